// File: doc/BRIEF.md
# Multicycle Fetch-Execute Processor Core

This block is a small processor core that runs each instruction as a series of clock-by-clock steps. All traffic goes through one read-only memory port. Every read, whether for an opcode, an operand byte or a data operand, goes through an address staging register and a data staging register. The opcode byte moves from the data staging register into the instruction register. Because instructions are one to four bytes long, the program counter moves forward by the length decoded from the opcode byte as soon as that byte is loaded.

Register-immediate and register-memory instructions take a destination register and a source value. The destination is also the first source (dst <- dst op src). A register-memory instruction makes a second read at a 16-bit direct address to get its source. Add and subtract update a condition code register that holds negative, zero, overflow and carry flags. Relative branches read those flags. A taken branch replaces the sequential PC with the branch target.

The memory port uses valid/ready. The core raises `mem_rd_valid` with an address and holds both unchanged until the memory raises `mem_rd_ready`. Read data is taken only in the cycle where both are high. The memory may hold `mem_rd_ready` low for as long as it needs, and the core waits in place. Three plain outputs give a debug view of the PC, the instruction register and the flags.

Top module: `fetch_exec_core`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `mem_rd_valid` is 0, `dbg_pc` equals the reset vector (default 0x0040), and `dbg_ir` and `dbg_flags` are 0. One clock edge after release, a read request for the reset vector is presented.
- R2: Once `mem_rd_valid` is high it stays high, with `mem_addr` unchanged, until a cycle in which `mem_rd_ready` is high. `mem_rdata` is used only in that cycle.
- R3: Bits [7:6] of the opcode byte give the instruction length: 00 means 1 byte, 01 means 2, 10 means 3 and 11 means 4. The operand bytes are read from the addresses that follow the opcode. The next opcode is fetched at the old PC plus the length.
- R4: Only 0x00 (no-op), 0x40-0x42, 0x80-0x82 and 0xC0-0xC2 are defined. Any other opcode byte runs as a one-byte no-op: no register or flag changes, and the next fetch is at PC+1.
- R5: For 0x80-0x82 (3 bytes) and 0xC0-0xC2 (4 bytes), opcode bits [1:0] select move (0), add (1) or subtract (2). Operand byte 1 bits [1:0] name the destination register. The destination receives dst+src, dst-src or src.
- R6: `dbg_flags` is {N,Z,V,C} in bits [3:0]. Only add and subtract write it. N is bit 7 of the result and Z means the result is zero. V is two's-complement overflow. C is the carry out for add and the borrow for subtract. Moves and loads leave the flags unchanged.
- R7: For the 4-byte forms, the source is read from the address formed by operand byte 2 (low) and operand byte 3 (high). This second read does not change the PC.
- R8: Opcode 0x41 branches when N differs from V. The target is the address after the 2-byte branch plus operand byte 1, sign-extended.
- R9: Opcode 0x40 always branches and opcode 0x42 branches when Z is 1. An untaken branch continues at the next sequential address.
- R10: With a memory that answers immediately, a one-byte instruction takes 5 cycles from the start of its fetch request to the start of the next fetch request.
- R11: `dbg_ir` holds the opcode byte of the most recently loaded instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Read address, taken from the address staging register |
| mem_rd_valid | output | 1 | Read request, held until accepted |
| mem_rd_ready | input | 1 | Memory accepts the request; read data is valid this cycle |
| mem_rdata | input | 8 | Read data |
| dbg_pc | output | 16 | Program counter |
| dbg_ir | output | 8 | Instruction register (opcode byte) |
| dbg_flags | output | 4 | Condition codes {N,Z,V,C} |

## Verification
Properties check on every cycle that the request stays held under back-pressure and that each fetch starts from the PC. They also check that the PC does not move during the data-read steps or after an untaken branch, that the flags change only in the execute step, and that an undefined opcode advances the PC by exactly one byte. Only directed programs can show the arithmetic results, the flag values for carry, borrow and overflow, and the correct branch targets. They also cover the value taken from a delayed memory read and the five-cycle timing of a one-byte instruction. Register contents are not visible at the ports, so the bench reads them indirectly through subtract-and-compare sequences on the flags.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FWAIT, ST_LOADIR, ST_OPWAIT, ST_DECODE,
    ST_DADDR, ST_DWAIT, ST_EXEC, ST_BRANCH
  } seq_e;

  typedef enum logic [1:0] {FMT_NONE = 2'd0, FMT_BR = 2'd1, FMT_IMM = 2'd2, FMT_MEM = 2'd3} fmt_e;
  typedef enum logic [1:0] {ALU_PASS = 2'd0, ALU_ADD = 2'd1, ALU_SUB = 2'd2, ALU_RSV = 2'd3} alu_e;
  typedef enum logic [1:0] {CC_ALWAYS = 2'd0, CC_LESS = 2'd1, CC_ZERO = 2'd2, CC_NEVER = 2'd3} cc_e;

  typedef struct packed {
    fmt_e       fmt;
    alu_e       op;
    cc_e        cc;
    logic       wr_reg;
    logic       wr_flags;
    logic [2:0] len;
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/fxc_decode.sv
module fxc_decode
  import fxc_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output dec_t              dec
);
  logic legal;

  always_comb begin
    dec = '{fmt: FMT_NONE, op: ALU_PASS, cc: CC_NEVER,
            wr_reg: 1'b0, wr_flags: 1'b0, len: 3'd1};
    legal = (opc[5:3] == 3'b000) && (opc[2:0] <= 3'd2);
    if (legal) begin
      case (opc[7:6])
        2'b01: begin
          dec.fmt = FMT_BR;
          dec.cc  = cc_e'(opc[1:0]);
          dec.len = 3'd2;
        end
        2'b10, 2'b11: begin
          dec.fmt      = fmt_e'(opc[7:6]);
          dec.op       = alu_e'(opc[1:0]);
          dec.wr_reg   = 1'b1;
          dec.wr_flags = (opc[1:0] != 2'b00);
          dec.len      = (opc[7:6] == 2'b10) ? 3'd3 : 3'd4;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fxc_alu.sv
module fxc_alu
  import fxc_pkg::*;
(
  input  alu_e              op,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output logic [BYTE_W-1:0] res,
  output flags_t            flg
);
  logic [BYTE_W:0] wide;

  always_comb begin
    wide  = '0;
    flg.v = 1'b0;
    case (op)
      ALU_ADD: begin
        wide  = {1'b0, a} + {1'b0, b};
        flg.v = (a[BYTE_W-1] == b[BYTE_W-1]) && (wide[BYTE_W-1] != a[BYTE_W-1]);
      end
      ALU_SUB: begin
        wide  = {1'b0, a} - {1'b0, b};
        flg.v = (a[BYTE_W-1] != b[BYTE_W-1]) && (wide[BYTE_W-1] != a[BYTE_W-1]);
      end
      default: wide = {1'b0, b};
    endcase
    res   = wide[BYTE_W-1:0];
    flg.c = wide[BYTE_W];
    flg.n = wide[BYTE_W-1];
    flg.z = (wide[BYTE_W-1:0] == '0);
  end
endmodule

// File: rtl/fxc_regfile.sv
module fxc_regfile
  import fxc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rsel,
  output logic [BYTE_W-1:0] rdata,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [BYTE_W-1:0] wdata
);
  logic [BYTE_W-1:0] rd_vec [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                               q <= '0;
      else if (we && (wsel == SEL_W'(g)))    q <= wdata;
    end
    assign rd_vec[g] = q;
  end

  assign rdata = rd_vec[rsel];
endmodule

// File: rtl/fetch_exec_core.sv
module fetch_exec_core
  import fxc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_REGS  = 4,
  parameter logic [15:0] RESET_VEC = 16'h0040
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [BYTE_W-1:0] dbg_ir,
  output logic [3:0]        dbg_flags
);
  localparam int SEL_W  = $clog2(NUM_REGS);
  localparam int OPND_N = 3;
  localparam int OPI_W  = $clog2(OPND_N);

  seq_e              state_q;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [BYTE_W-1:0] mdr_q, ir_q;
  logic [BYTE_W-1:0] opnd_q [OPND_N];
  logic [OPI_W-1:0]  opi_q;
  flags_t            flags_q;

  dec_t              dec;
  logic [BYTE_W-1:0] dec_in;
  logic [BYTE_W-1:0] reg_a, alu_b, alu_res;
  flags_t            alu_flg;
  logic              taken, last_opnd, reg_we;
  logic [ADDR_W-1:0] rel_ext, data_ptr;

  assign dec_in = (state_q == ST_LOADIR) ? mdr_q : ir_q;

  fxc_decode u_dec (.opc(dec_in), .dec(dec));

  assign alu_b  = (dec.fmt == FMT_MEM) ? mdr_q : opnd_q[1];
  assign reg_we = (state_q == ST_EXEC) && dec.wr_reg;

  fxc_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst(rst),
    .rsel(opnd_q[0][SEL_W-1:0]), .rdata(reg_a),
    .we(reg_we), .wsel(opnd_q[0][SEL_W-1:0]), .wdata(alu_res)
  );

  fxc_alu u_alu (.op(dec.op), .a(reg_a), .b(alu_b), .res(alu_res), .flg(alu_flg));

  always_comb begin
    case (dec.cc)
      CC_ALWAYS: taken = 1'b1;
      CC_LESS:   taken = flags_q.n ^ flags_q.v;
      CC_ZERO:   taken = flags_q.z;
      default:   taken = 1'b0;
    endcase
  end

  assign rel_ext   = {{(ADDR_W-BYTE_W){opnd_q[0][BYTE_W-1]}}, opnd_q[0]};
  assign data_ptr  = ADDR_W'({opnd_q[2], opnd_q[1]});
  assign last_opnd = ({1'b0, opi_q} == (dec.len - 3'd2));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FADDR;
      pc_q    <= ADDR_W'(RESET_VEC);
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      opi_q   <= '0;
      flags_q <= '0;
      for (int i = 0; i < OPND_N; i++) opnd_q[i] <= '0;
    end else begin
      case (state_q)
        ST_FADDR: begin
          mar_q   <= pc_q;
          state_q <= ST_FWAIT;
        end
        ST_FWAIT: if (mem_rd_ready) begin
          mdr_q   <= mem_rdata;
          state_q <= ST_LOADIR;
        end
        ST_LOADIR: begin
          ir_q  <= mdr_q;
          pc_q  <= pc_q + ADDR_W'(dec.len);
          opi_q <= '0;
          if (dec.len > 3'd1) begin
            mar_q   <= mar_q + ADDR_W'(1);
            state_q <= ST_OPWAIT;
          end else begin
            state_q <= ST_DECODE;
          end
        end
        ST_OPWAIT: if (mem_rd_ready) begin
          opnd_q[opi_q] <= mem_rdata;
          opi_q         <= opi_q + OPI_W'(1);
          mar_q         <= mar_q + ADDR_W'(1);
          if (last_opnd) state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          case (dec.fmt)
            FMT_MEM: state_q <= ST_DADDR;
            FMT_BR:  state_q <= ST_BRANCH;
            default: state_q <= ST_EXEC;
          endcase
        end
        ST_DADDR: begin
          mar_q   <= data_ptr;
          state_q <= ST_DWAIT;
        end
        ST_DWAIT: if (mem_rd_ready) begin
          mdr_q   <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (dec.wr_flags) flags_q <= alu_flg;
          state_q <= ST_FADDR;
        end
        ST_BRANCH: begin
          if (taken) pc_q <= pc_q + rel_ext;
          state_q <= ST_FADDR;
        end
        default: state_q <= ST_FADDR;
      endcase
    end
  end

  assign mem_addr     = mar_q;
  assign mem_rd_valid = (state_q == ST_FWAIT) || (state_q == ST_OPWAIT) || (state_q == ST_DWAIT);
  assign dbg_pc       = pc_q;
  assign dbg_ir       = ir_q;
  assign dbg_flags    = flags_q;

  logic undef_op;
  assign undef_op = (mdr_q[5:3] != 3'b000) ||
                    ((mdr_q[7:6] == 2'b00) && (mdr_q[2:0] != 3'd0)) ||
                    ((mdr_q[7:6] != 2'b00) && (mdr_q[2:0] > 3'd2));

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr)))
    else $error("request dropped or address moved under back-pressure"); // R2

  AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FADDR) |=> (mem_rd_valid && mem_addr == $past(pc_q)))
    else $error("opcode fetch not at PC"); // R3

  AST_UNDEF_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOADIR && undef_op) |=> (state_q == ST_DECODE && pc_q == $past(pc_q) + ADDR_W'(1)))
    else $error("undefined opcode not a one-byte no-op"); // R4

  AST_FLAGS_ONLY_EXEC: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_EXEC) |=> $stable(flags_q))
    else $error("flags changed outside execute"); // R6

  AST_DATA_READ_PC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DADDR || state_q == ST_DWAIT) |=> $stable(pc_q))
    else $error("PC moved during data read"); // R7

  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BRANCH && !taken) |=> $stable(pc_q))
    else $error("untaken branch moved PC"); // R9
endmodule

// File: tb/sim_fetch_exec_core.sv
`timescale 1ns/1ps
module sim_fetch_exec_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd_valid, mem_rd_ready;
  logic [7:0]  mem_rdata;
  logic [15:0] dbg_pc;
  logic [7:0]  dbg_ir;
  logic [3:0]  dbg_flags;

  int checks = 0;
  int errors = 0;
  int wait_n = 0;
  int wcnt   = 0;
  int stall_err = 0;
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr  = '0;
  logic        seen_data  = 1'b0;
  logic [7:0]  mem [0:1023];

  always #2.5 clk = ~clk;

  fetch_exec_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rdata(mem_rdata),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_flags(dbg_flags)
  );

  assign mem_rd_ready = mem_rd_valid && (wcnt == 0);
  assign mem_rdata    = mem_rd_ready ? mem[mem_addr[9:0]] : 8'hA5;

  always @(posedge clk) begin
    if (rst || !mem_rd_valid || mem_rd_ready) wcnt <= wait_n;
    else wcnt <= wcnt - 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && !(mem_rd_valid && mem_addr == prev_addr)) stall_err++;
      if (mem_rd_valid && mem_rd_ready && mem_addr == 16'h0300) seen_data = 1'b1;
    end
    prev_stall = !rst && mem_rd_valid && !mem_rd_ready;
    prev_addr  = mem_addr;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to(input string req, input logic [15:0] a);
    int n = 0;
    while (mem_rd_valid && n < 300) begin @(negedge clk); n++; end
    while (!(mem_rd_valid && mem_addr == a && dbg_pc == a) && n < 300) begin
      @(negedge clk); n++;
    end
    checks++;
    if (n >= 300) begin
      errors++;
      $display("FAIL %s: fetch at %h never seen, actual pc %h expected %h", req, a, dbg_pc, a);
    end
  endtask

  // R1 R4 R6 R10 R11: reset state, no-op timing, undefined opcodes
  task automatic t_reset_and_noops();
    int cyc;
    clear_mem();
    wait_n = 0;
    put(16'h40, 8'h00);
    put(16'h41, 8'h82); put(16'h42, 8'h00); put(16'h43, 8'h01); // SUB r0,1
    put(16'h44, 8'hFF); put(16'h45, 8'h05); put(16'h46, 8'h7F);
    put(16'h47, 8'h40); put(16'h48, 8'hFE);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {15'd0, mem_rd_valid}, 16'd0);
    check("R1 pc in reset", dbg_pc, 16'h0040);
    check("R1 ir in reset", {8'd0, dbg_ir}, 16'd0);
    check("R1 flags in reset", {12'd0, dbg_flags}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first request", {15'd0, mem_rd_valid}, 16'd1);
    check("R1 first address", mem_addr, 16'h0040);
    cyc = 0;
    do begin @(negedge clk); cyc++; end
    while (!(mem_rd_valid && mem_addr == 16'h41 && dbg_pc == 16'h41) && cyc < 50);
    check("R10 one-byte cycles", 16'(cyc), 16'd5);
    run_to("R3 after 3-byte", 16'h44);
    check("R6 sub borrow flags", {12'd0, dbg_flags}, 16'h9);
    run_to("R4 after 0xFF", 16'h45);
    run_to("R4 after 0x05", 16'h46);
    run_to("R4 after 0x7F", 16'h47);
    check("R4 flags untouched", {12'd0, dbg_flags}, 16'h9);
    check("R11 ir shows last opcode", {8'd0, dbg_ir}, 16'h007F);
  endtask

  // R5 R6 R8: add overflow, JL not taken with N=V=1, subtract to zero
  task automatic t_imm_ops();
    clear_mem();
    wait_n = 2;
    put(16'h40, 8'h80); put(16'h41, 8'h01); put(16'h42, 8'h7F); // MOV r1,7F
    put(16'h43, 8'h81); put(16'h44, 8'h01); put(16'h45, 8'h01); // ADD r1,1
    put(16'h46, 8'h41); put(16'h47, 8'h02);                     // JL +2
    put(16'h48, 8'h82); put(16'h49, 8'h01); put(16'h4A, 8'h80); // SUB r1,80
    put(16'h4B, 8'h40); put(16'h4C, 8'hFE);
    do_reset();
    run_to("R5 after add", 16'h46);
    check("R6 add overflow flags", {12'd0, dbg_flags}, 16'hA);
    run_to("R8 JL not taken when N=V", 16'h48);
    run_to("R5 after sub", 16'h4B);
    check("R5 move+add then sub to zero", {12'd0, dbg_flags}, 16'h4);
  endtask

  // R2 R6 R7: direct-memory forms under wait states
  task automatic t_mem_ops();
    clear_mem();
    wait_n = 3;
    seen_data = 1'b0;
    put(16'h300, 8'h22); put(16'h301, 8'h05);
    put(16'h40, 8'h82); put(16'h41, 8'h00); put(16'h42, 8'h01);                     // SUB r0,1
    put(16'h43, 8'hC0); put(16'h44, 8'h02); put(16'h45, 8'h00); put(16'h46, 8'h03); // LD r2,[0300]
    put(16'h47, 8'h82); put(16'h48, 8'h02); put(16'h49, 8'h22);                     // SUB r2,22
    put(16'h4A, 8'hC1); put(16'h4B, 8'h02); put(16'h4C, 8'h01); put(16'h4D, 8'h03); // ADD r2,[0301]
    put(16'h4E, 8'h82); put(16'h4F, 8'h02); put(16'h50, 8'h06);                     // SUB r2,6
    put(16'h51, 8'h40); put(16'h52, 8'hFE);
    do_reset();
    run_to("R7 after load", 16'h47);
    check("R6 load keeps flags", {12'd0, dbg_flags}, 16'h9);
    check("R11 ir after load", {8'd0, dbg_ir}, 16'h00C0);
    run_to("R7 after compare", 16'h4A);
    check("R7 loaded value", {12'd0, dbg_flags}, 16'h4);
    run_to("R7 after mem add", 16'h4E);
    check("R7 mem add flags", {12'd0, dbg_flags}, 16'h0);
    run_to("R7 after last sub", 16'h51);
    check("R7 mem add result", {12'd0, dbg_flags}, 16'h9);
    check("R7 data address read", {15'd0, seen_data}, 16'd1);
  endtask

  // R8 R9: taken and untaken branches, backward jump
  task automatic t_branches();
    clear_mem();
    wait_n = 1;
    put(16'h40, 8'h82); put(16'h41, 8'h00); put(16'h42, 8'h01); // SUB r0,1 -> N
    put(16'h43, 8'h41); put(16'h44, 8'h04);                     // JL +4 -> 49
    put(16'h45, 8'h40); put(16'h46, 8'hFE);                     // trap
    put(16'h49, 8'h80); put(16'h4A, 8'h03); put(16'h4B, 8'h01); // MOV r3,1
    put(16'h4C, 8'h81); put(16'h4D, 8'h03); put(16'h4E, 8'h00); // ADD r3,0
    put(16'h4F, 8'h41); put(16'h50, 8'h02);                     // JL +2 not taken
    put(16'h51, 8'h42); put(16'h52, 8'h02);                     // JZ +2 not taken
    put(16'h53, 8'h82); put(16'h54, 8'h03); put(16'h55, 8'h01); // SUB r3,1 -> Z
    put(16'h56, 8'h42); put(16'h57, 8'h03);                     // JZ +3 -> 5B
    put(16'h58, 8'h40); put(16'h59, 8'hFE);                     // trap
    put(16'h5B, 8'h40); put(16'h5C, 8'hFE);                     // JMP self
    do_reset();
    run_to("R8 JL taken", 16'h49);
    run_to("R8 JL not taken when N=V=0", 16'h51);
    run_to("R9 JZ not taken", 16'h53);
    run_to("R9 JZ taken", 16'h5B);
    run_to("R9 JMP backward", 16'h5B);
    check("R9 pc on self loop", dbg_pc, 16'h005B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_noops();
    t_imm_ops();
    t_mem_ops();
    t_branches();
    check("R2 request held under back-pressure", 16'(stall_err), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule